// File: doc/BRIEF.md
# Flash Page-Block Write Guard

This block decides, one request at a time, whether a write or erase aimed at the user area of an on-chip flash may go ahead. It holds a register of per-block enable bits. A bit at 1 leaves its block of pages writable, and a bit at 0 locks that block. After reset the register first has to be filled from a configuration word that the boot path fetches and presents on a load port. Until that word arrives, every request is refused.

Once the load has happened, software may tighten protection by writing to the register. A write can only lock further blocks. It never unlocks one, and the only way back is another reset.

Each request carries a byte address. The guard drops the offset inside the page, finds the block the page belongs to, and answers on the next cycle. It either passes the request on with its address, or raises a one-cycle refusal. Any address beyond the user area is refused.

Top module: `flash_wprot`

## Requirements
- R1: During reset and in the first cycle after it, `loadDone` is 0, `lockMask` reads 0x00000000, and neither `reqGrant` nor `reqDeny` is high.
- R2: While the load is pending, the first cycle with `cfgValid` high copies `cfgWord` into the register. From the next cycle `loadDone` is 1 and `lockMask` equals that word. Any later `cfgValid` pulse has no effect until the next reset.
- R3: After the load, a cycle with `swWrEn` high sets the register to its old value ANDed with `swWrData`, visible on `lockMask` the next cycle. A software write made while the load is pending has no effect.
- R4: A bit that reads 0 on `lockMask` after the load stays 0 until reset, whatever software writes. Writing 1 bits never sets a bit.
- R5: For a request with byte address A below 0x40000, the block index is A[17:13]. Each block covers eight 1 KB pages, and bits A[9:0] have no effect. If mask bit A[17:13] is 1, the cycle after the request has `reqGrant` high and `fwdAddr` equal to A. If the bit is 0, that cycle has `reqDeny` high instead.
- R6: A request with a byte address of 0x40000 or more is refused, whatever the mask holds.
- R7: Every request cycle produces exactly one of `reqGrant` and `reqDeny` on the following cycle, for one cycle each. A cycle with no request produces neither on the following cycle.
- R8: While the load is pending, every request is refused.
- R9: A request made in the same cycle as a software write is judged against the mask as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Reset-time configuration word is present |
| cfgWord | input | 32 | Configuration word holding the initial block enables |
| swWrEn | input | 1 | Software write to the lock register |
| swWrData | input | 32 | Software write data; 0 bits lock blocks |
| reqValid | input | 1 | A write or erase request is presented |
| reqAddr | input | 20 | Byte address of the request |
| lockMask | output | 32 | Current block enables (1 = writable) |
| loadDone | output | 1 | The configuration word has been loaded |
| reqGrant | output | 1 | One-cycle pulse: the previous request is forwarded |
| reqDeny | output | 1 | One-cycle pulse: the previous request is refused |
| fwdAddr | output | 20 | Address of the request being judged |

## Verification
The bench walks every page of the user area, plus a run of pages above it, under four loaded masks. All-open and all-locked masks show whether the index is used at all. An alternating irregular mask catches a wrong or shifted index field. A mask with a single open block exposes any decode that is off by one block. Page offsets vary from request to request, which shows that the low address bits are ignored. Requests issued before the load, requests issued in the same cycle as a software write, and writes made of all-ones data separate the pending refusal, the before-write decision and the one-way clearing from one another.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  typedef enum logic [0:0] {
    ST_AWAIT_CFG = 1'b0,
    ST_ENFORCE   = 1'b1
  } guard_state_t;

  typedef struct packed {
    logic loadMask;
    logic clearMask;
    logic evalReq;
    logic forceDeny;
  } guard_strobe_t;

endpackage

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgValid,
  input  logic          swWrEn,
  input  logic          reqValid,
  output guard_strobe_t strb,
  output logic          loadDone
);

  guard_state_t state;
  guard_state_t stateNext;

  always_comb begin
    stateNext = state;
    if (state == ST_AWAIT_CFG && cfgValid) stateNext = ST_ENFORCE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_AWAIT_CFG;
    else       state <= stateNext;
  end

  always_comb begin
    strb.loadMask  = (state == ST_AWAIT_CFG) && cfgValid;
    strb.clearMask = (state == ST_ENFORCE) && swWrEn;
    strb.evalReq   = reqValid;
    strb.forceDeny = (state == ST_AWAIT_CFG);
  end

  assign loadDone = (state == ST_ENFORCE);

endmodule

// File: rtl/wprot_datapath.sv
module wprot_datapath
  import wprot_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int PAGE_LOG2      = 10,
  parameter int BLK_PAGES_LOG2 = 3,
  parameter int NUM_BLK        = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  guard_strobe_t      strb,
  input  logic [NUM_BLK-1:0] cfgWord,
  input  logic [NUM_BLK-1:0] swWrData,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic [NUM_BLK-1:0] lockMask,
  output logic               reqGrant,
  output logic               reqDeny,
  output logic [ADDR_W-1:0]  fwdAddr
);

  localparam int BLK_IDX_W = $clog2(NUM_BLK);
  localparam int BLK_LSB   = PAGE_LOG2 + BLK_PAGES_LOG2;
  localparam int USER_LOG2 = BLK_LSB + BLK_IDX_W;

  logic [NUM_BLK-1:0]   maskReg;
  logic [BLK_IDX_W-1:0] blkIdx;
  logic                 inUser;
  logic                 blkOpen;
  logic                 passReq;

  // Lock register: filled once from the configuration word, then only cleared.
  always_ff @(posedge clk) begin
    if (!rstN)               maskReg <= '0;
    else if (strb.loadMask)  maskReg <= cfgWord;
    else if (strb.clearMask) maskReg <= maskReg & swWrData;
  end

  assign blkIdx = reqAddr[BLK_LSB +: BLK_IDX_W];

  generate
    if (ADDR_W > USER_LOG2) begin : g_rangeChk
      assign inUser = ~|reqAddr[ADDR_W-1:USER_LOG2];
    end else begin : g_noRangeChk
      assign inUser = 1'b1;
    end
  endgenerate

  assign blkOpen = maskReg[blkIdx];
  assign passReq = strb.evalReq && !strb.forceDeny && inUser && blkOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqGrant <= 1'b0;
      reqDeny  <= 1'b0;
      fwdAddr  <= '0;
    end else begin
      reqGrant <= passReq;
      reqDeny  <= strb.evalReq && !passReq;
      if (strb.evalReq) fwdAddr <= reqAddr;
    end
  end

  assign lockMask = maskReg;

endmodule

// File: rtl/flash_wprot.sv
module flash_wprot
  import wprot_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int PAGE_LOG2      = 10,
  parameter int BLK_PAGES_LOG2 = 3,
  parameter int NUM_BLK        = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgValid,
  input  logic [NUM_BLK-1:0] cfgWord,
  input  logic               swWrEn,
  input  logic [NUM_BLK-1:0] swWrData,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic [NUM_BLK-1:0] lockMask,
  output logic               loadDone,
  output logic               reqGrant,
  output logic               reqDeny,
  output logic [ADDR_W-1:0]  fwdAddr
);

  guard_strobe_t strb;

  wprot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgValid (cfgValid),
    .swWrEn   (swWrEn),
    .reqValid (reqValid),
    .strb     (strb),
    .loadDone (loadDone)
  );

  wprot_datapath #(
    .ADDR_W         (ADDR_W),
    .PAGE_LOG2      (PAGE_LOG2),
    .BLK_PAGES_LOG2 (BLK_PAGES_LOG2),
    .NUM_BLK        (NUM_BLK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgWord  (cfgWord),
    .swWrData (swWrData),
    .reqAddr  (reqAddr),
    .lockMask (lockMask),
    .reqGrant (reqGrant),
    .reqDeny  (reqDeny),
    .fwdAddr  (fwdAddr)
  );

endmodule

// File: rtl/flash_wprot_chk.sv
module flash_wprot_chk #(
  parameter int ADDR_W    = 20,
  parameter int NUM_BLK   = 32,
  parameter int USER_LOG2 = 18
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgValid,
  input logic               swWrEn,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic [NUM_BLK-1:0] lockMask,
  input logic               loadDone,
  input logic               reqGrant,
  input logic               reqDeny,
  input logic [ADDR_W-1:0]  fwdAddr
);

  // R4: no bit goes from 0 back to 1 while enforcing
  a_r4_one_way: assert property (@(posedge clk) disable iff (!rstN)
    ($past(loadDone) && loadDone) |-> ((~$past(lockMask) & lockMask) == '0));

  // R7: grant and deny never together, and only after a request
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(reqGrant && reqDeny));
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid) |=> (!reqGrant && !reqDeny));

  // R8: pending load refuses everything
  a_r8_pending_deny: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !loadDone) |=> reqDeny);

  // R6: outside the user area is never granted
  a_r6_range: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (|(reqAddr >> USER_LOG2))) |=> !reqGrant);

  // R5: a granted request forwards its address
  a_r5_fwd_addr: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (fwdAddr == $past(reqAddr)));

  // R2 / R3: the mask only moves on a load or a software write
  a_r3_mask_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgValid && !swWrEn) |=> $stable(lockMask));

endmodule

bind flash_wprot flash_wprot_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_BLK   (NUM_BLK),
  .USER_LOG2 (PAGE_LOG2 + BLK_PAGES_LOG2 + $clog2(NUM_BLK))
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgValid (cfgValid),
  .swWrEn   (swWrEn),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .lockMask (lockMask),
  .loadDone (loadDone),
  .reqGrant (reqGrant),
  .reqDeny  (reqDeny),
  .fwdAddr  (fwdAddr)
);

// File: tb/test_flash_wprot.sv
module test_flash_wprot;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        swWrEn = 1'b0;
  logic [31:0] swWrData = '0;
  logic        reqValid = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [31:0] lockMask;
  logic        loadDone;
  logic        reqGrant;
  logic        reqDeny;
  logic [19:0] fwdAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_wprot i_flash_wprot (
    .clk      (clk),
    .rstN     (rstN),
    .cfgValid (cfgValid),
    .cfgWord  (cfgWord),
    .swWrEn   (swWrEn),
    .swWrData (swWrData),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .lockMask (lockMask),
    .loadDone (loadDone),
    .reqGrant (reqGrant),
    .reqDeny  (reqDeny),
    .fwdAddr  (fwdAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cfgValid = 1'b0; swWrEn = 1'b0; reqValid = 1'b0;
    step(); step();
    check(loadDone == 1'b0, "R1 loadDone", {31'd0, loadDone}, 32'd0);
    check(lockMask == 32'd0, "R1 mask", lockMask, 32'd0);
    check(!reqGrant && !reqDeny, "R1 outputs", {30'd0, reqGrant, reqDeny}, 32'd0);
    rstN = 1'b1;
    step();
    check(loadDone == 1'b0 && lockMask == 32'd0, "R1 after release", lockMask, 32'd0);
  endtask

  task automatic loadCfg(input logic [31:0] w);
    cfgValid = 1'b1; cfgWord = w;
    step();
    cfgValid = 1'b0;
    check(loadDone == 1'b1, "R2 loadDone", {31'd0, loadDone}, 32'd1);
    check(lockMask == w, "R2 mask", lockMask, w);
  endtask

  // One request; judge it one cycle later against mask m / pending flag.
  task automatic oneReq(input logic [19:0] a, input logic [31:0] m, input bit pending, input string req);
    bit expGrant;
    reqValid = 1'b1; reqAddr = a;
    step();
    reqValid = 1'b0;
    expGrant = !pending && (a < 20'h40000) && m[a[17:13]];
    check(reqGrant == expGrant && reqDeny == !expGrant, req,
          {30'd0, reqGrant, reqDeny}, {30'd0, expGrant, !expGrant});
    if (expGrant) check(fwdAddr == a, "R5 fwdAddr", {12'd0, fwdAddr}, {12'd0, a});
  endtask

  task automatic sweep(input logic [31:0] m);
    for (int p = 0; p < 264; p++) begin
      logic [19:0] a;
      a = 20'(p * 1024 + ((p * 37 + 5) % 1024));
      oneReq(a, m, 1'b0, (p < 256) ? "R5 page sweep" : "R6 out of range");
    end
    oneReq(20'hFFFFF, m, 1'b0, "R6 top address");
    // R7: idle cycle gives no pulse
    step();
    check(!reqGrant && !reqDeny, "R7 idle", {30'd0, reqGrant, reqDeny}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      summary();
    end
  end

  initial begin
    logic [31:0] masks [4];
    masks[0] = 32'hFFFFFFFF;
    masks[1] = 32'h00000000;
    masks[2] = 32'hA5C396E1;
    masks[3] = 32'h00010000;

    // R8 / R3: behaviour while the load is pending
    doReset();
    oneReq(20'h00000, 32'hFFFFFFFF, 1'b1, "R8 pending deny");
    oneReq(20'h2A000, 32'hFFFFFFFF, 1'b1, "R8 pending deny");
    swWrEn = 1'b1; swWrData = 32'h0;
    step();
    swWrEn = 1'b0;
    check(lockMask == 32'd0 && loadDone == 1'b0, "R3 write while pending", lockMask, 32'd0);
    loadCfg(32'h12345678);
    // R2: a second config pulse is ignored
    cfgValid = 1'b1; cfgWord = 32'hFFFFFFFF;
    step();
    cfgValid = 1'b0;
    check(lockMask == 32'h12345678, "R2 second load ignored", lockMask, 32'h12345678);

    for (int k = 0; k < 4; k++) begin
      doReset();
      loadCfg(masks[k]);
      sweep(masks[k]);
    end

    // R3 / R4: AND writes and one-way clearing
    doReset();
    loadCfg(32'hFFFFFFFF);
    swWrEn = 1'b1; swWrData = 32'hFFFF0FFF;
    step();
    check(lockMask == 32'hFFFF0FFF, "R3 and write", lockMask, 32'hFFFF0FFF);
    swWrData = 32'hFFFFFFFF;
    step();
    check(lockMask == 32'hFFFF0FFF, "R4 ones do not set", lockMask, 32'hFFFF0FFF);
    swWrData = 32'h0000FFFF;
    step();
    swWrEn = 1'b0;
    check(lockMask == 32'h00000FFF, "R3 and write 2", lockMask, 32'h00000FFF);
    cfgValid = 1'b1; cfgWord = 32'hFFFFFFFF;
    step();
    cfgValid = 1'b0;
    check(lockMask == 32'h00000FFF, "R4 reload blocked", lockMask, 32'h00000FFF);
    sweep(32'h00000FFF);

    // R9: request and clearing write in the same cycle
    reqValid = 1'b1; reqAddr = 20'h00123;
    swWrEn = 1'b1; swWrData = 32'hFFFFFFFE;
    step();
    reqValid = 1'b0; swWrEn = 1'b0;
    check(reqGrant && !reqDeny, "R9 old mask used", {30'd0, reqGrant, reqDeny}, 32'd2);
    check(lockMask == 32'h00000FFE, "R9 write applied", lockMask, 32'h00000FFE);
    oneReq(20'h00123, 32'h00000FFE, 1'b0, "R9 next request denied");

    finished = 1'b1;
    summary();
  end

endmodule